// File: doc/BRIEF.md
# BCD Real-Time Clock Register File

This block keeps calendar time as packed BCD counters: seconds, minutes, hours, day of week, date, month and a two-digit year. Year 00 stands for 1968, and the counters advance by one second on each pulse of a once-per-second tick input. The carry chain follows month lengths and the leap-year rule, so the date, month and year roll over correctly. Day of week counts 01 to 07 and moves on at each midnight.

Software reaches the block through an eight-byte window on a byte-wide bus. The window has address, write data and read data, plus read and write strobes. Offset 0 is a control byte and offsets 1 to 7 hold the time fields, in the order seconds, minutes, hours, day of week, date, month, year. The control byte has two protocol bits:

- A freeze bit holds a readable snapshot, so a read of several bytes sees a single instant.
- A stage bit collects new time values and commits them together when it is cleared.

A few flag bits sit above the BCD value fields in the time bytes: a stop flag, a kick-start flag and a frequency-test flag.

Top module: `rtc_bcd_regs`

## Requirements
- R1: After reset the control byte reads 0x00 and the time reads seconds 00, minutes 00, hours 00, day of week 01, date 01, month 01, year 00, with all flags clear and `ftest_o` low.
- R2: A read strobe at offset 0..7 (0 control, 1 seconds, 2 minutes, 3 hours, 4 day of week, 5 date, 6 month, 7 year) puts the byte on `rdata_o` at the next clock edge. The byte carries the BCD value in its field (seconds/minutes bits 6:0, hours bits 5:0, day of week bits 2:0, date bits 5:0, month bits 4:0, year bits 7:0) and the flags: stop at seconds bit 7, kick-start at hours bit 7, frequency test at day-of-week bit 6. All other bits read 0.
- R3: Each accepted tick adds one to the seconds in BCD. Seconds 59 wraps to 00 and carries into minutes, minutes 59 wraps to 00 and carries into hours, and hours 23 wraps to 00 and carries into the date.
- R4: At each midnight rollover, day of week steps forward and wraps from 07 to 01. The date wraps to 01 and carries into the month after 30 in months 04, 06, 09 and 11, and after 31 in the other months except February.
- R5: February ends after 29 when the year value is a multiple of four (00 included) and after 28 otherwise. Month 12 wraps to 01 and carries into the year, and year 99 wraps to 00.
- R6: While the stop flag (seconds bit 7) is set, tick pulses are ignored and no time field changes.
- R7: Writing control bit 7 from 0 to 1 captures the running time into a staging copy. While bit 7 is set, writes to offsets 1..7 change only the staging copy, and the running counters keep counting. Clearing bit 7 loads the whole staging copy into the counters at that edge, including the fields that were not written.
- R8: While control bit 7 is clear, a write to offsets 1..7 leaves the BCD value fields unchanged.
- R9: While control bit 6 is set, reads of offsets 1..7 return the time as it was when the bit was set, and the counters keep running. Once bit 6 is cleared, reads follow the running time again.
- R10: Control bit 5 (calibration sign) and bits 4:0 (calibration magnitude) are stored and read back. The kick-start and frequency-test flags take the written bit on any write to their register, whatever control bit 7 holds. They read back without changing any BCD value.
- R11: While the frequency-test flag is set, `ftest_o` toggles on every tick pulse, and it holds while the flag is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | One-cycle pulse once per second |
| addr_i | input | 3 | Byte offset inside the register window |
| wdata_i | input | 8 | Write data |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Registered read data |
| ftest_o | output | 1 | Frequency-test output |

## Verification
The block has fixed result timing:

- A write, a tick or a commit takes effect at the rising edge where its strobe is sampled.
- A read strobe sampled at an edge shows its byte on `rdata_o` right after that same edge.

The bench changes every input at a falling edge and holds it for one full cycle. It reads results at the falling edge that follows the sampling edge. This means each check looks at a value exactly one register stage after its stimulus. Tick-dependent results are checked only after the tick pulse has been withdrawn.

// File: rtl/rtc_pkg.sv
// Package: shared types, window offsets and BCD helpers for the real-time clock.
// Assumes all time values are packed BCD; helpers do not repair invalid digits.
package rtc_pkg;

    localparam int BYTE_W = 8;
    localparam int OFS_W  = 3;

    // Window offsets: the decode order is fixed by the register layout.
    localparam logic [OFS_W-1:0] OFS_CTRL = 3'd0;
    localparam logic [OFS_W-1:0] OFS_SEC  = 3'd1;
    localparam logic [OFS_W-1:0] OFS_MIN  = 3'd2;
    localparam logic [OFS_W-1:0] OFS_HOUR = 3'd3;
    localparam logic [OFS_W-1:0] OFS_DOW  = 3'd4;
    localparam logic [OFS_W-1:0] OFS_DATE = 3'd5;
    localparam logic [OFS_W-1:0] OFS_MON  = 3'd6;
    localparam logic [OFS_W-1:0] OFS_YEAR = 3'd7;

    // Control byte bit positions.
    localparam int CTL_STAGE  = 7;
    localparam int CTL_FREEZE = 6;

    typedef struct packed {
        logic [7:0] year;
        logic [4:0] mon;
        logic [5:0] date;
        logic [2:0] dow;
        logic [5:0] hour;
        logic [6:0] min;
        logic [6:0] sec;
    } rtc_time_t;

    localparam rtc_time_t TIME_RESET = '{year: 8'h00, mon: 5'h01, date: 6'h01,
                                         dow: 3'h1, hour: 6'h00, min: 7'h00, sec: 7'h00};

    // Add one to a two-digit packed BCD value (no wrap; caller handles limits).
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // True when a two-digit BCD value is a multiple of four.
    function automatic logic bcd_mult4(input logic [7:0] v);
        if (v[4]) return (v[3:0] == 4'd2) || (v[3:0] == 4'd6);
        return (v[3:0] == 4'd0) || (v[3:0] == 4'd4) || (v[3:0] == 4'd8);
    endfunction

endpackage

// File: rtl/rtc_month_len.sv
// Module: last valid date (BCD) of a month, given month and two-digit year.
// Assumes year 00 is a leap year, so any multiple of four gives a 29-day February.
module rtc_month_len
    import rtc_pkg::*;
(
    input  logic [4:0] mon_i,
    input  logic [7:0] year_i,
    output logic [5:0] last_o
);

    // Pick the month length from the month value and the leap rule.
    always_comb begin
        case (mon_i)
            5'h02:                      last_o = bcd_mult4(year_i) ? 6'h29 : 6'h28;
            5'h04, 5'h06, 5'h09, 5'h11: last_o = 6'h30;
            default:                    last_o = 6'h31;
        endcase
    end

endmodule

// File: rtl/rtc_time_chain.sv
// Module: running BCD time counters with the full carry chain.
// Assumes load_i and adv_i are qualified by the caller; load takes priority.
module rtc_time_chain
    import rtc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      adv_i,
    input  logic      load_i,
    input  rtc_time_t load_val_i,
    output rtc_time_t cur_o
);

    rtc_time_t  cur_q;
    logic [5:0] last_day;
    logic       sec_end, min_end, hour_end, date_end, mon_end;

    rtc_month_len u_len (
        .mon_i  (cur_q.mon),
        .year_i (cur_q.year),
        .last_o (last_day)
    );

    // Detect the terminal value of each field.
    always_comb begin
        sec_end  = (cur_q.sec  == 7'h59);
        min_end  = (cur_q.min  == 7'h59);
        hour_end = (cur_q.hour == 6'h23);
        date_end = (cur_q.date == last_day);
        mon_end  = (cur_q.mon  == 5'h12);
    end

    // Advance the chain on a tick, or load the staged time on a commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= TIME_RESET;
        end else if (load_i) begin
            cur_q <= load_val_i;
        end else if (adv_i) begin
            cur_q.sec <= sec_end ? 7'h00 : 7'(bcd_inc({1'b0, cur_q.sec}));
            if (sec_end) begin
                cur_q.min <= min_end ? 7'h00 : 7'(bcd_inc({1'b0, cur_q.min}));
                if (min_end) begin
                    cur_q.hour <= hour_end ? 6'h00 : 6'(bcd_inc({2'b0, cur_q.hour}));
                    if (hour_end) begin
                        cur_q.dow  <= (cur_q.dow == 3'h7) ? 3'h1 : cur_q.dow + 3'h1;
                        cur_q.date <= date_end ? 6'h01 : 6'(bcd_inc({2'b0, cur_q.date}));
                        if (date_end) begin
                            cur_q.mon <= mon_end ? 5'h01 : 5'(bcd_inc({3'b0, cur_q.mon}));
                            if (mon_end) cur_q.year <= (cur_q.year == 8'h99) ? 8'h00 : bcd_inc(cur_q.year);
                        end
                    end
                end
            end
        end
    end

    assign cur_o = cur_q;

    // R7: a commit lands the staged time exactly.
    a_r7_commit_exact: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (cur_q == $past(load_val_i)));

    // R3: seconds wrap from 59 to 00 on an accepted tick.
    a_r3_sec_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !load_i && sec_end) |=> (cur_q.sec == 7'h00));

    // R4: day of week wraps from 07 to 01 at midnight.
    a_r4_dow_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !load_i && sec_end && min_end && hour_end && cur_q.dow == 3'h7)
        |=> (cur_q.dow == 3'h1));

endmodule

// File: rtl/rtc_bcd_regs.sv
// Module: byte-wide register window around the BCD time chain.
// Holds the control byte, the flags above the value fields, the staging
// copy used for atomic writes and the snapshot used for consistent reads.
// Assumes tick_i is a single-cycle pulse and software writes valid BCD.
module rtc_bcd_regs
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic [OFS_W-1:0]  addr_i,
    input  logic [BYTE_W-1:0] wdata_i,
    input  logic              wr_i,
    input  logic              rd_i,
    output logic [BYTE_W-1:0] rdata_o,
    output logic              ftest_o
);

    logic [BYTE_W-1:0] ctrl_q;
    logic              stop_q, kick_q, ftst_q;
    rtc_time_t         stage_q, snap_q, cur, view;
    logic              wr_ctrl, stage_open, stage_commit, adv;

    // Decode control writes that open or commit the staging copy.
    always_comb begin
        wr_ctrl      = wr_i && (addr_i == OFS_CTRL);
        stage_open   = wr_ctrl &&  wdata_i[CTL_STAGE] && !ctrl_q[CTL_STAGE];
        stage_commit = wr_ctrl && !wdata_i[CTL_STAGE] &&  ctrl_q[CTL_STAGE];
        adv          = tick_i && !stop_q;
    end

    rtc_time_chain u_chain (
        .clk        (clk),
        .rst_n      (rst_n),
        .adv_i      (adv),
        .load_i     (stage_commit),
        .load_val_i (stage_q),
        .cur_o      (cur)
    );

    // Store the control byte.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (wr_ctrl) ctrl_q <= wdata_i;
    end

    // Store the flag bits; they bypass staging.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stop_q <= 1'b0;
            kick_q <= 1'b0;
            ftst_q <= 1'b0;
        end else if (wr_i) begin
            if (addr_i == OFS_SEC)  stop_q <= wdata_i[7];
            if (addr_i == OFS_HOUR) kick_q <= wdata_i[7];
            if (addr_i == OFS_DOW)  ftst_q <= wdata_i[6];
        end
    end

    // Capture the running time on open, then collect value writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= TIME_RESET;
        end else if (stage_open) begin
            stage_q <= cur;
        end else if (wr_i && ctrl_q[CTL_STAGE]) begin
            case (addr_i)
                OFS_SEC:  stage_q.sec  <= wdata_i[6:0];
                OFS_MIN:  stage_q.min  <= wdata_i[6:0];
                OFS_HOUR: stage_q.hour <= wdata_i[5:0];
                OFS_DOW:  stage_q.dow  <= wdata_i[2:0];
                OFS_DATE: stage_q.date <= wdata_i[5:0];
                OFS_MON:  stage_q.mon  <= wdata_i[4:0];
                OFS_YEAR: stage_q.year <= wdata_i;
                default:  ;
            endcase
        end
    end

    // Track the running time into the snapshot unless reads are frozen.
    always_ff @(posedge clk) begin
        if (!rst_n)                    snap_q <= TIME_RESET;
        else if (!ctrl_q[CTL_FREEZE])  snap_q <= cur;
    end

    // Choose the time copy that reads see.
    always_comb view = ctrl_q[CTL_FREEZE] ? snap_q : cur;

    // Register the addressed byte on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_o <= '0;
        end else if (rd_i) begin
            case (addr_i)
                OFS_CTRL: rdata_o <= ctrl_q;
                OFS_SEC:  rdata_o <= {stop_q, view.sec};
                OFS_MIN:  rdata_o <= {1'b0, view.min};
                OFS_HOUR: rdata_o <= {kick_q, 1'b0, view.hour};
                OFS_DOW:  rdata_o <= {1'b0, ftst_q, 3'b0, view.dow};
                OFS_DATE: rdata_o <= {2'b0, view.date};
                OFS_MON:  rdata_o <= {3'b0, view.mon};
                default:  rdata_o <= view.year;
            endcase
        end
    end

    // Toggle the test output on each tick while the test flag is set.
    always_ff @(posedge clk) begin
        if (!rst_n)                ftest_o <= 1'b0;
        else if (tick_i && ftst_q) ftest_o <= ~ftest_o;
    end

    // R6: a stopped clock ignores ticks.
    a_r6_stop_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && stop_q && !stage_commit) |=> $stable(cur));

    // R9: the snapshot stays put while reads are frozen.
    a_r9_snap_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q[CTL_FREEZE] |=> $stable(snap_q));

    // R11: the test output flips on every tick while enabled.
    a_r11_ftest_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && ftst_q) |=> (ftest_o != $past(ftest_o)));

    // R11: the test output holds while disabled.
    a_r11_ftest_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !ftst_q |=> $stable(ftest_o));

endmodule

// File: tb/tb_rtc_bcd_regs.sv
module tb_rtc_bcd_regs;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic [2:0] addr_i = '0;
    logic [7:0] wdata_i = '0;
    logic       wr_i = 1'b0;
    logic       rd_i = 1'b0;
    logic [7:0] rdata_o;
    logic       ftest_o;

    int  n_run  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #5 clk = ~clk;

    rtc_bcd_regs dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick_i),
        .addr_i  (addr_i),
        .wdata_i (wdata_i),
        .wr_i    (wr_i),
        .rd_i    (rd_i),
        .rdata_o (rdata_o),
        .ftest_o (ftest_o)
    );

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        addr_i = a; wdata_i = d; wr_i = 1'b1;
        @(negedge clk);
        wr_i = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk);
        tick_i = 1'b1;
        @(negedge clk);
        tick_i = 1'b0;
    endtask

    task automatic chk(input logic [2:0] a, input logic [7:0] exp, input string req);
        @(negedge clk);
        addr_i = a; rd_i = 1'b1;
        @(negedge clk);
        rd_i = 1'b0;
        n_run++;
        if (rdata_o !== exp) begin
            n_fail++;
            $display("FAIL %s offset %0d: got %02h expected %02h", req, a, rdata_o, exp);
        end
    endtask

    task automatic chk_bit(input logic act, input logic exp, input string req);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic set_time(input logic [7:0] s, m, h, dw, dt, mo, yr);
        wr(3'd0, 8'h80);
        wr(3'd1, s); wr(3'd2, m); wr(3'd3, h); wr(3'd4, dw);
        wr(3'd5, dt); wr(3'd6, mo); wr(3'd7, yr);
        wr(3'd0, 8'h00);
    endtask

    task automatic t_reset();
        chk(3'd0, 8'h00, "R1"); chk(3'd1, 8'h00, "R1"); chk(3'd2, 8'h00, "R1");
        chk(3'd3, 8'h00, "R1"); chk(3'd4, 8'h01, "R1"); chk(3'd5, 8'h01, "R1");
        chk(3'd6, 8'h01, "R1"); chk(3'd7, 8'h00, "R1");
        chk_bit(ftest_o, 1'b0, "R1 ftest_o");
    endtask

    task automatic t_carry();
        set_time(8'h58, 8'h59, 8'h23, 8'h07, 8'h28, 8'h02, 8'h03);
        chk(3'd1, 8'h58, "R2 seconds readback");
        chk(3'd7, 8'h03, "R2 year readback");
        tick(); chk(3'd1, 8'h59, "R3 seconds step");
        tick();
        chk(3'd1, 8'h00, "R3 seconds wrap"); chk(3'd2, 8'h00, "R3 minutes wrap");
        chk(3'd3, 8'h00, "R3 hours wrap");   chk(3'd4, 8'h01, "R4 dow 07 to 01");
        chk(3'd5, 8'h01, "R5 feb 28 ends");  chk(3'd6, 8'h03, "R5 month step");
        chk(3'd7, 8'h03, "R5 year kept");
    endtask

    task automatic t_leap();
        set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h04);
        tick();
        chk(3'd5, 8'h29, "R5 leap feb 29"); chk(3'd6, 8'h02, "R5 leap month");
        chk(3'd4, 8'h04, "R4 dow step");
        set_time(8'h59, 8'h59, 8'h23, 8'h04, 8'h29, 8'h02, 8'h04);
        tick();
        chk(3'd5, 8'h01, "R5 leap feb end"); chk(3'd6, 8'h03, "R5 leap to march");
    endtask

    task automatic t_months();
        set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h30, 8'h04, 8'h10);
        tick();
        chk(3'd5, 8'h01, "R4 30-day month"); chk(3'd6, 8'h05, "R4 30-day month");
        set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h30, 8'h01, 8'h10);
        tick();
        chk(3'd5, 8'h31, "R4 31-day month");
        set_time(8'h59, 8'h59, 8'h23, 8'h05, 8'h31, 8'h12, 8'h99);
        tick();
        chk(3'd5, 8'h01, "R5 year end date"); chk(3'd6, 8'h01, "R5 month wrap");
        chk(3'd7, 8'h00, "R5 year 99 wrap");  chk(3'd4, 8'h06, "R4 dow step");
    endtask

    task automatic t_stop();
        wr(3'd1, 8'h80);
        chk(3'd1, 8'h80, "R6 stop flag set");
        tick(); tick(); tick();
        chk(3'd1, 8'h80, "R6 ticks ignored");
        chk(3'd2, 8'h00, "R6 minutes held");
        wr(3'd1, 8'h00);
        tick();
        chk(3'd1, 8'h01, "R6 runs after release");
    endtask

    task automatic t_ignore();
        wr(3'd2, 8'h33);
        chk(3'd2, 8'h00, "R8 minutes write ignored");
        wr(3'd7, 8'h42);
        chk(3'd7, 8'h00, "R8 year write ignored");
    endtask

    task automatic t_stage();
        wr(3'd0, 8'h80);
        wr(3'd2, 8'h45);
        tick();
        chk(3'd1, 8'h02, "R7 counters run while staging");
        chk(3'd2, 8'h00, "R7 staged value hidden");
        wr(3'd0, 8'h00);
        chk(3'd2, 8'h45, "R7 commit written field");
        chk(3'd1, 8'h01, "R7 commit unwritten field");
    endtask

    task automatic t_freeze();
        wr(3'd0, 8'h40);
        tick(); tick();
        chk(3'd1, 8'h01, "R9 frozen seconds");
        chk(3'd0, 8'h40, "R9 control readback");
        wr(3'd0, 8'h00);
        chk(3'd1, 8'h03, "R9 resumed tracking");
    endtask

    task automatic t_flags();
        wr(3'd0, 8'h3A);
        chk(3'd0, 8'h3A, "R10 calibration stored");
        wr(3'd3, 8'hC5);
        chk(3'd3, 8'h80, "R10 kick flag, hours kept");
        wr(3'd4, 8'h43);
        chk(3'd4, 8'h46, "R10 test flag, dow kept");
    endtask

    task automatic t_ftest();
        logic f0;
        @(negedge clk);
        f0 = ftest_o;
        tick();
        chk_bit(ftest_o, ~f0, "R11 toggle on tick");
        tick();
        chk_bit(ftest_o, f0, "R11 toggle back");
        wr(3'd4, 8'h00);
        tick();
        chk_bit(ftest_o, f0, "R11 hold when clear");
        chk(3'd4, 8'h06, "R11 dow unchanged");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_carry();
        t_leap();
        t_months();
        t_stop();
        t_ignore();
        t_stage();
        t_freeze();
        t_flags();
        t_ftest();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule